// File: doc/BRIEF.md
# Dual-Bank Processor Register File

This block is the architectural register store of a small processor core whose address registers can be 16 or 24 bits wide. Two identical banks each hold four 16-bit data registers (D0 to D3) and four address-class registers: two address registers (X0, X1), a base pointer and a frame pointer. Which bank is used is decided by one bit of the status word, and every access goes to that bank. Outside the banks sit a user stack pointer, an interrupt stack pointer, a 24-bit vector base register kept as a 16-bit low part and an 8-bit high part, a program counter and a 16-bit status word.

The core names a register with a 5-bit identifier. Some identifiers are views that span several physical registers: a single byte of D0 or D1, a 32-bit pair of data or address registers, or a 64-bit group of all four data registers in one of two orders. One identifier is a stack pointer view that follows the user-mode bit of the status word. The read port is combinational and returns the selected view zero-extended to 64 bits. The write port stores a 64-bit value into the selected view on the rising clock edge. The pointer-mode input sets the width of the address registers and the program counter. It is applied both when a value is written and when it is read.

Top module: `bank_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every register of both banks, both stack pointers, the vector base, the program counter and the status word, so every identifier reads 0 afterwards. An identifier above 24 always reads 0.
- R2: Bit 4 of the status word (identifier 24) selects the bank. Data and address-class accesses reach only the selected bank, and a write leaves the other bank unchanged.
- R3: Identifiers 1 and 4 are the high bytes of D0 (id 0) and D1 (id 3). Identifiers 2 and 5 are their low bytes. A byte write stores wr_data[7:0] into that byte and keeps the other byte. A byte read returns the byte in bits 7:0.
- R4: Identifier 8 is a 32-bit pair with D2 (id 6) in bits 31:16 and D0 in bits 15:0. Identifier 9 is a pair with D3 (id 7) high and D1 low.
- R5: Identifier 10 is a 64-bit group ordered D3, D1, D2, D0 from bit 63 downward. Identifier 11 is ordered D3, D2, D1, D0.
- R6: With wide_ptr low, X0 (12), X1 (13), base (15), frame (16), SP (20), user SP (21) and interrupt SP (22) are limited to 16 bits and the PC (23) to 20 bits. With wide_ptr high all of them are 24 bits. The limit applies on write and again on read.
- R7: Identifier 20 accesses the user stack pointer when status bit 7 is 1 and the interrupt stack pointer when it is 0. The other pointer is not touched.
- R8: The vector base (17) writes bits 15:0 to its low half (18) and bits 23:16 to its high half (19). It reads back as {high, low}. A write to the high half takes wr_data[7:0].
- R9: Identifier 14 reads {X1[15:0], X0[15:0]} in either pointer mode. A write to it stores bits 15:0 in X0 and bits 31:16 in X1.
- R10: A write to an identifier above 24 changes no register. wr_err is 1 in the cycle after that write and 0 after any cycle without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_ptr | input | 1 | 1 selects 24-bit pointer mode, 0 selects 16-bit mode |
| wr_en | input | 1 | Write strobe |
| wr_id | input | 5 | Identifier of the write target |
| wr_data | input | 64 | Write value |
| rd_id | input | 5 | Identifier of the read target |
| rd_data | output | 64 | Read value, combinational |
| wr_err | output | 1 | Registered flag for a write to an unknown identifier |

## Verification
The hardest case to reach is a value in the bank that is not selected. The ports never name that bank directly, so it can only be seen by writing the status word to switch banks and then reading. The stimulus fills bank 0, moves to bank 1 and finds it empty, writes there, and switches back to show both contents survived. Pointer width behaves in a similar hidden way. The bench stores a 24-bit value, narrows the mode, and reads the upper bits as hidden rather than lost. It also stores a value in narrow mode and reads it in wide mode to show the upper bits were never kept.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;

    localparam int DW     = 16;   // data register width
    localparam int AW     = 24;   // address register storage width
    localparam int XW     = 64;   // port width
    localparam int IDW    = 5;    // identifier width
    localparam int N_DATA = 4;    // data registers per bank
    localparam int N_ADDR = 4;    // address-class registers per bank
    localparam int N_BANK = 2;

    // address-class slot numbers inside a bank
    localparam int XS_X0    = 0;
    localparam int XS_X1    = 1;
    localparam int XS_BASE  = 2;
    localparam int XS_FRAME = 3;

    localparam logic [IDW-1:0] ID_D0      = 5'd0;
    localparam logic [IDW-1:0] ID_D0_HI   = 5'd1;
    localparam logic [IDW-1:0] ID_D0_LO   = 5'd2;
    localparam logic [IDW-1:0] ID_D1      = 5'd3;
    localparam logic [IDW-1:0] ID_D1_HI   = 5'd4;
    localparam logic [IDW-1:0] ID_D1_LO   = 5'd5;
    localparam logic [IDW-1:0] ID_D2      = 5'd6;
    localparam logic [IDW-1:0] ID_D3      = 5'd7;
    localparam logic [IDW-1:0] ID_PAIR20  = 5'd8;
    localparam logic [IDW-1:0] ID_PAIR31  = 5'd9;
    localparam logic [IDW-1:0] ID_QUAD_A  = 5'd10;
    localparam logic [IDW-1:0] ID_QUAD_B  = 5'd11;
    localparam logic [IDW-1:0] ID_X0      = 5'd12;
    localparam logic [IDW-1:0] ID_X1      = 5'd13;
    localparam logic [IDW-1:0] ID_XPAIR   = 5'd14;
    localparam logic [IDW-1:0] ID_BASE    = 5'd15;
    localparam logic [IDW-1:0] ID_FRAME   = 5'd16;
    localparam logic [IDW-1:0] ID_VEC     = 5'd17;
    localparam logic [IDW-1:0] ID_VEC_LO  = 5'd18;
    localparam logic [IDW-1:0] ID_VEC_HI  = 5'd19;
    localparam logic [IDW-1:0] ID_SP      = 5'd20;
    localparam logic [IDW-1:0] ID_USTK    = 5'd21;
    localparam logic [IDW-1:0] ID_ISTK    = 5'd22;
    localparam logic [IDW-1:0] ID_PC      = 5'd23;
    localparam logic [IDW-1:0] ID_STAT    = 5'd24;

    typedef logic [N_DATA-1:0][DW-1:0] data_set_t;
    typedef logic [N_ADDR-1:0][AW-1:0] addr_set_t;

endpackage

// File: rtl/rf_bank.sv
module rf_bank
    import bank_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DATA-1:0] d_we,
    input  data_set_t         d_wd,
    input  logic [N_ADDR-1:0] x_we,
    input  addr_set_t         x_wd,
    output data_set_t         d_q,
    output addr_set_t         x_q
);

    for (genvar i = 0; i < N_DATA; i++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       d_q[i] <= '0;
            else if (d_we[i]) d_q[i] <= d_wd[i];
        end
    end

    for (genvar j = 0; j < N_ADDR; j++) begin : g_addr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       x_q[j] <= '0;
            else if (x_we[j]) x_q[j] <= x_wd[j];
        end
    end

    // R2: a bank that receives no enable keeps its contents
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|d_we) && !(|x_we)) |=> ($stable(d_q) && $stable(x_q)));

endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
    import bank_regfile_pkg::*;
(
    input  logic                wr_en,
    input  logic [IDW-1:0]      wr_id,
    input  logic [XW-1:0]       wd,
    input  logic [1:0][DW-1:0]  cur_byte_regs,  // active D0, D1 for byte merges
    input  logic [AW-1:0]       amask,
    input  logic [AW-1:0]       pcmask,
    input  logic                user_mode,
    output logic [N_DATA-1:0]   d_we,
    output data_set_t           d_wd,
    output logic [N_ADDR-1:0]   x_we,
    output addr_set_t           x_wd,
    output logic                us_we,
    output logic                is_we,
    output logic [AW-1:0]       stk_wd,
    output logic                vl_we,
    output logic [15:0]         vl_wd,
    output logic                vh_we,
    output logic [7:0]          vh_wd,
    output logic                pc_we,
    output logic [AW-1:0]       pc_wd,
    output logic                st_we,
    output logic [DW-1:0]       st_wd,
    output logic                bad
);

    logic [AW-1:0] wd_addr;
    assign wd_addr = wd[AW-1:0] & amask;

    always_comb begin
        d_we   = '0;
        d_wd   = '0;
        x_we   = '0;
        x_wd   = '0;
        us_we  = 1'b0;
        is_we  = 1'b0;
        stk_wd = wd_addr;
        vl_we  = 1'b0;
        vl_wd  = wd[15:0];
        vh_we  = 1'b0;
        vh_wd  = wd[7:0];
        pc_we  = 1'b0;
        pc_wd  = wd[AW-1:0] & pcmask;
        st_we  = 1'b0;
        st_wd  = wd[DW-1:0];
        bad    = 1'b0;
        if (wr_en) begin
            unique case (wr_id)
                ID_D0:     begin d_we[0] = 1'b1; d_wd[0] = wd[15:0]; end
                ID_D0_HI:  begin d_we[0] = 1'b1; d_wd[0] = {wd[7:0], cur_byte_regs[0][7:0]}; end
                ID_D0_LO:  begin d_we[0] = 1'b1; d_wd[0] = {cur_byte_regs[0][15:8], wd[7:0]}; end
                ID_D1:     begin d_we[1] = 1'b1; d_wd[1] = wd[15:0]; end
                ID_D1_HI:  begin d_we[1] = 1'b1; d_wd[1] = {wd[7:0], cur_byte_regs[1][7:0]}; end
                ID_D1_LO:  begin d_we[1] = 1'b1; d_wd[1] = {cur_byte_regs[1][15:8], wd[7:0]}; end
                ID_D2:     begin d_we[2] = 1'b1; d_wd[2] = wd[15:0]; end
                ID_D3:     begin d_we[3] = 1'b1; d_wd[3] = wd[15:0]; end
                ID_PAIR20: begin
                    d_we[2] = 1'b1; d_wd[2] = wd[31:16];
                    d_we[0] = 1'b1; d_wd[0] = wd[15:0];
                end
                ID_PAIR31: begin
                    d_we[3] = 1'b1; d_wd[3] = wd[31:16];
                    d_we[1] = 1'b1; d_wd[1] = wd[15:0];
                end
                ID_QUAD_A: begin
                    d_we    = '1;
                    d_wd[3] = wd[63:48];
                    d_wd[1] = wd[47:32];
                    d_wd[2] = wd[31:16];
                    d_wd[0] = wd[15:0];
                end
                ID_QUAD_B: begin
                    d_we    = '1;
                    d_wd[3] = wd[63:48];
                    d_wd[2] = wd[47:32];
                    d_wd[1] = wd[31:16];
                    d_wd[0] = wd[15:0];
                end
                ID_X0:     begin x_we[XS_X0]    = 1'b1; x_wd[XS_X0]    = wd_addr; end
                ID_X1:     begin x_we[XS_X1]    = 1'b1; x_wd[XS_X1]    = wd_addr; end
                ID_BASE:   begin x_we[XS_BASE]  = 1'b1; x_wd[XS_BASE]  = wd_addr; end
                ID_FRAME:  begin x_we[XS_FRAME] = 1'b1; x_wd[XS_FRAME] = wd_addr; end
                ID_XPAIR:  begin
                    x_we[XS_X0] = 1'b1; x_wd[XS_X0] = AW'(wd[15:0]);
                    x_we[XS_X1] = 1'b1; x_wd[XS_X1] = AW'(wd[31:16]);
                end
                ID_VEC:    begin
                    vl_we = 1'b1;
                    vh_we = 1'b1;
                    vh_wd = wd[23:16];
                end
                ID_VEC_LO: vl_we = 1'b1;
                ID_VEC_HI: vh_we = 1'b1;
                ID_SP:     begin us_we = user_mode; is_we = !user_mode; end
                ID_USTK:   us_we = 1'b1;
                ID_ISTK:   is_we = 1'b1;
                ID_PC:     pc_we = 1'b1;
                ID_STAT:   st_we = 1'b1;
                default:   bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux
    import bank_regfile_pkg::*;
(
    input  logic [IDW-1:0] rd_id,
    input  data_set_t      d_q,
    input  addr_set_t      x_q,
    input  logic [AW-1:0]  ustk_q,
    input  logic [AW-1:0]  istk_q,
    input  logic [15:0]    vlo_q,
    input  logic [7:0]     vhi_q,
    input  logic [AW-1:0]  pc_q,
    input  logic [DW-1:0]  stat_q,
    input  logic [AW-1:0]  amask,
    input  logic [AW-1:0]  pcmask,
    input  logic           user_mode,
    output logic [XW-1:0]  rd_data
);

    always_comb begin
        unique case (rd_id)
            ID_D0:     rd_data = XW'(d_q[0]);
            ID_D0_HI:  rd_data = XW'(d_q[0][15:8]);
            ID_D0_LO:  rd_data = XW'(d_q[0][7:0]);
            ID_D1:     rd_data = XW'(d_q[1]);
            ID_D1_HI:  rd_data = XW'(d_q[1][15:8]);
            ID_D1_LO:  rd_data = XW'(d_q[1][7:0]);
            ID_D2:     rd_data = XW'(d_q[2]);
            ID_D3:     rd_data = XW'(d_q[3]);
            ID_PAIR20: rd_data = XW'({d_q[2], d_q[0]});
            ID_PAIR31: rd_data = XW'({d_q[3], d_q[1]});
            ID_QUAD_A: rd_data = {d_q[3], d_q[1], d_q[2], d_q[0]};
            ID_QUAD_B: rd_data = {d_q[3], d_q[2], d_q[1], d_q[0]};
            ID_X0:     rd_data = XW'(x_q[XS_X0] & amask);
            ID_X1:     rd_data = XW'(x_q[XS_X1] & amask);
            ID_XPAIR:  rd_data = XW'({x_q[XS_X1][15:0], x_q[XS_X0][15:0]});
            ID_BASE:   rd_data = XW'(x_q[XS_BASE] & amask);
            ID_FRAME:  rd_data = XW'(x_q[XS_FRAME] & amask);
            ID_VEC:    rd_data = XW'({vhi_q, vlo_q});
            ID_VEC_LO: rd_data = XW'(vlo_q);
            ID_VEC_HI: rd_data = XW'(vhi_q);
            ID_SP:     rd_data = XW'((user_mode ? ustk_q : istk_q) & amask);
            ID_USTK:   rd_data = XW'(ustk_q & amask);
            ID_ISTK:   rd_data = XW'(istk_q & amask);
            ID_PC:     rd_data = XW'(pc_q & pcmask);
            ID_STAT:   rd_data = XW'(stat_q);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_regfile_pkg::*;
#(
    parameter int BANK_BIT   = 4,
    parameter int USER_BIT   = 7,
    parameter int NARROW_AW  = 16,
    parameter int NARROW_PCW = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wide_ptr,
    input  logic           wr_en,
    input  logic [4:0]     wr_id,
    input  logic [63:0]    wr_data,
    input  logic [4:0]     rd_id,
    output logic [63:0]    rd_data,
    output logic           wr_err
);

    localparam logic [AW-1:0] AMASK_N  = AW'((64'd1 << NARROW_AW) - 64'd1);
    localparam logic [AW-1:0] PCMASK_N = AW'((64'd1 << NARROW_PCW) - 64'd1);

    // system registers
    logic [AW-1:0] ustk_q, istk_q, pc_q;
    logic [15:0]   vlo_q;
    logic [7:0]    vhi_q;
    logic [DW-1:0] stat_q;
    logic          err_q;

    logic          bank_sel, user_mode;
    logic [AW-1:0] amask, pcmask;

    assign bank_sel  = stat_q[BANK_BIT];
    assign user_mode = stat_q[USER_BIT];
    assign amask     = wide_ptr ? '1 : AMASK_N;
    assign pcmask    = wide_ptr ? '1 : PCMASK_N;

    // bank storage
    data_set_t [N_BANK-1:0] bank_d;
    addr_set_t [N_BANK-1:0] bank_x;
    data_set_t              act_d;
    addr_set_t              act_x;

    assign act_d = bank_d[bank_sel];
    assign act_x = bank_x[bank_sel];

    // decoded write
    logic [N_DATA-1:0] d_we;
    data_set_t         d_wd;
    logic [N_ADDR-1:0] x_we;
    addr_set_t         x_wd;
    logic              us_we, is_we, vl_we, vh_we, pc_we, st_we, bad;
    logic [AW-1:0]     stk_wd, pc_wd;
    logic [15:0]       vl_wd;
    logic [7:0]        vh_wd;
    logic [DW-1:0]     st_wd;

    rf_wr_decode u_dec (
        .wr_en         (wr_en),
        .wr_id         (wr_id),
        .wd            (wr_data),
        .cur_byte_regs ({act_d[1], act_d[0]}),
        .amask         (amask),
        .pcmask        (pcmask),
        .user_mode     (user_mode),
        .d_we          (d_we),
        .d_wd          (d_wd),
        .x_we          (x_we),
        .x_wd          (x_wd),
        .us_we         (us_we),
        .is_we         (is_we),
        .stk_wd        (stk_wd),
        .vl_we         (vl_we),
        .vl_wd         (vl_wd),
        .vh_we         (vh_we),
        .vh_wd         (vh_wd),
        .pc_we         (pc_we),
        .pc_wd         (pc_wd),
        .st_we         (st_we),
        .st_wd         (st_wd),
        .bad           (bad)
    );

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic hit;
        assign hit = (bank_sel == 1'(b));
        rf_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .d_we  (hit ? d_we : '0),
            .d_wd  (d_wd),
            .x_we  (hit ? x_we : '0),
            .x_wd  (x_wd),
            .d_q   (bank_d[b]),
            .x_q   (bank_x[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ustk_q <= '0;
            istk_q <= '0;
            vlo_q  <= '0;
            vhi_q  <= '0;
            pc_q   <= '0;
            stat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (us_we) ustk_q <= stk_wd;
            if (is_we) istk_q <= stk_wd;
            if (vl_we) vlo_q  <= vl_wd;
            if (vh_we) vhi_q  <= vh_wd;
            if (pc_we) pc_q   <= pc_wd;
            if (st_we) stat_q <= st_wd;
            err_q <= bad;
        end
    end

    assign wr_err = err_q;

    rf_rd_mux u_rd (
        .rd_id     (rd_id),
        .d_q       (act_d),
        .x_q       (act_x),
        .ustk_q    (ustk_q),
        .istk_q    (istk_q),
        .vlo_q     (vlo_q),
        .vhi_q     (vhi_q),
        .pc_q      (pc_q),
        .stat_q    (stat_q),
        .amask     (amask),
        .pcmask    (pcmask),
        .user_mode (user_mode),
        .rd_data   (rd_data)
    );

    // R10: error flag follows an unknown write by one cycle, and clears
    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_id > ID_STAT)) |=> wr_err);
    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

    // R6: narrow pointer mode hides upper address and PC bits on the port
    p_narrow_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_ptr && rd_id == ID_X0) |-> (rd_data[63:NARROW_AW] == '0));
    p_narrow_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_ptr && rd_id == ID_PC) |-> (rd_data[63:NARROW_PCW] == '0));

    // R3: a high-byte write keeps the low byte
    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == ID_D0_HI) |=> (act_d[0][7:0] == $past(act_d[0][7:0])));

    // R2: writes other than the status word never reach the other bank
    p_other_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id != ID_STAT) |=>
            (bank_d[!bank_sel] == $past(bank_d[!bank_sel]) &&
             bank_x[!bank_sel] == $past(bank_x[!bank_sel])));

    // R7: a stack-pointer write in user mode leaves the interrupt pointer alone
    p_sp_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id == ID_SP && user_mode) |=> $stable(istk_q));

endmodule

// File: tb/tb_bank_regfile.sv
`timescale 1ns/1ps
module tb_bank_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_ptr = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_id = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_id = '0;
    logic [63:0] rd_data;
    logic        wr_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bank_regfile dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide_ptr (wide_ptr),
        .wr_en    (wr_en),
        .wr_id    (wr_id),
        .wr_data  (wr_data),
        .rd_id    (rd_id),
        .rd_data  (rd_data),
        .wr_err   (wr_err)
    );

    // scoreboard
    logic [63:0] q_exp[$];
    bit          q_err[$];
    bit          q_dat[$];
    string       q_tag[$];

    task automatic push(input logic [63:0] e, input bit er, input bit dat, input string tag);
        q_exp.push_back(e);
        q_err.push_back(er);
        q_dat.push_back(dat);
        q_tag.push_back(tag);
    endtask

    task automatic wr(input logic [4:0] id, input logic [63:0] v, input bit bad, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_id = id; wr_data = v;
        push('0, bad, 1'b0, tag);
    endtask

    task automatic rd(input logic [4:0] id, input logic [63:0] e, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_id = id;
        push(e, 1'b0, 1'b1, tag);
    endtask

    task automatic mode(input bit w);
        @(negedge clk);
        wr_en = 1'b0; wide_ptr = w;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tag.size() > 0) begin
                logic [63:0] e;
                bit er, dat;
                string tag;
                e = q_exp.pop_front();
                er = q_err.pop_front();
                dat = q_dat.pop_front();
                tag = q_tag.pop_front();
                checks++;
                if (wr_err !== er) begin
                    failures++;
                    $display("FAIL %s wr_err actual=%0b expected=%0b", tag, wr_err, er);
                end
                if (dat) begin
                    checks++;
                    if (rd_data !== e) begin
                        failures++;
                        $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset, unknown reads zero
        for (int i = 0; i < 25; i++) rd(5'(i), 64'h0, "R1 reset");
        rd(5'd30, 64'h0, "R1 unknown read");

        // R3: byte views
        wr(5'd0, 64'h1234, 0, "R3 wr");
        rd(5'd0, 64'h1234, "R3 full");
        wr(5'd1, 64'hFFAB, 0, "R3 wr hi");
        rd(5'd0, 64'hAB34, "R3 hi keeps lo");
        wr(5'd2, 64'h77CD, 0, "R3 wr lo");
        rd(5'd0, 64'hABCD, "R3 lo keeps hi");
        rd(5'd1, 64'hAB, "R3 rd hi");
        rd(5'd2, 64'hCD, "R3 rd lo");
        wr(5'd5, 64'h5A, 0, "R3 wr d1 lo");
        wr(5'd4, 64'hA5, 0, "R3 wr d1 hi");
        rd(5'd3, 64'hA55A, "R3 d1");
        rd(5'd4, 64'hA5, "R3 d1 hi");

        // R4: pairs
        wr(5'd8, 64'h1111_2222, 0, "R4 wr pair20");
        rd(5'd6, 64'h1111, "R4 d2");
        rd(5'd0, 64'h2222, "R4 d0");
        rd(5'd8, 64'h1111_2222, "R4 pair20");
        wr(5'd9, 64'h3333_4444, 0, "R4 wr pair31");
        rd(5'd9, 64'h3333_4444, "R4 pair31");
        rd(5'd7, 64'h3333, "R4 d3");

        // R5: quad orderings
        wr(5'd10, 64'h4444_3333_2222_1111, 0, "R5 wr quadA");
        rd(5'd11, 64'h4444_2222_3333_1111, "R5 quadB view");
        rd(5'd10, 64'h4444_3333_2222_1111, "R5 quadA view");
        wr(5'd11, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R5 wr quadB");
        rd(5'd10, 64'hAAAA_CCCC_BBBB_DDDD, "R5 quadA after B");
        rd(5'd1, 64'hDD, "R5 d0 hi");

        // R6: pointer width
        wr(5'd12, 64'hABCDEF, 0, "R6 wr x0 narrow");
        rd(5'd12, 64'hCDEF, "R6 x0 narrow");
        wr(5'd23, 64'hFFFFFF, 0, "R6 wr pc narrow");
        rd(5'd23, 64'h0FFFFF, "R6 pc narrow");
        mode(1'b1);
        wr(5'd12, 64'hABCDEF, 0, "R6 wr x0 wide");
        rd(5'd12, 64'hABCDEF, "R6 x0 wide");
        wr(5'd23, 64'h123456, 0, "R6 wr pc wide");
        rd(5'd23, 64'h123456, "R6 pc wide");
        mode(1'b0);
        rd(5'd12, 64'hCDEF, "R6 x0 read narrowed");
        rd(5'd23, 64'h023456, "R6 pc read narrowed");
        wr(5'd16, 64'hFEDCBA, 0, "R6 wr frame narrow");
        mode(1'b1);
        rd(5'd16, 64'hDCBA, "R6 frame stored narrow");

        // R9: address pair
        wr(5'd13, 64'h123456, 0, "R9 wr x1");
        rd(5'd14, 64'h3456_CDEF, "R9 xpair low halves");
        wr(5'd14, 64'h9999_8888, 0, "R9 wr xpair");
        rd(5'd12, 64'h8888, "R9 x0");
        rd(5'd13, 64'h9999, "R9 x1");

        // R2: banks
        wr(5'd24, 64'h0010, 0, "R2 sel bank1");
        rd(5'd0, 64'h0, "R2 bank1 empty");
        rd(5'd24, 64'h0010, "R2 status");
        wr(5'd0, 64'h5555, 0, "R2 wr bank1");
        rd(5'd0, 64'h5555, "R2 bank1 d0");
        rd(5'd12, 64'h0, "R2 bank1 x0");
        wr(5'd24, 64'h0000, 0, "R2 sel bank0");
        rd(5'd0, 64'hDDDD, "R2 bank0 kept");
        rd(5'd12, 64'h8888, "R2 bank0 x0 kept");
        wr(5'd24, 64'h0010, 0, "R2 sel bank1 again");
        rd(5'd0, 64'h5555, "R2 bank1 kept");

        // R7: stack pointer view
        wr(5'd24, 64'h0000, 0, "R7 sup mode");
        wr(5'd20, 64'h100, 0, "R7 wr sp sup");
        rd(5'd22, 64'h100, "R7 istk");
        rd(5'd21, 64'h0, "R7 ustk untouched");
        rd(5'd20, 64'h100, "R7 sp sup");
        wr(5'd24, 64'h0080, 0, "R7 user mode");
        rd(5'd20, 64'h0, "R7 sp user");
        wr(5'd20, 64'h200, 0, "R7 wr sp user");
        rd(5'd21, 64'h200, "R7 ustk");
        rd(5'd22, 64'h100, "R7 istk untouched");
        wr(5'd21, 64'hABCDEF, 0, "R6 wr ustk wide");
        mode(1'b0);
        rd(5'd20, 64'hCDEF, "R6 sp narrow");
        wr(5'd24, 64'h0000, 0, "R7 back to sup");

        // R8: vector base
        wr(5'd17, 64'hABCD_EF12, 0, "R8 wr vec");
        rd(5'd17, 64'hCDEF12, "R8 vec");
        wr(5'd19, 64'h177, 0, "R8 wr hi");
        rd(5'd17, 64'h77EF12, "R8 vec after hi");
        wr(5'd18, 64'h3456, 0, "R8 wr lo");
        rd(5'd17, 64'h773456, "R8 vec after lo");
        rd(5'd18, 64'h3456, "R8 lo");
        rd(5'd19, 64'h77, "R8 hi");

        // R10: unknown write
        wr(5'd27, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R10 bad wr");
        rd(5'd0, 64'hDDDD, "R10 d0 unchanged, err cleared");
        wr(5'd31, 64'h0010, 1, "R10 bad wr 31");
        rd(5'd24, 64'h0, "R10 status unchanged");

        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule